// File: doc/BRIEF.md
# Data Memory Address and Stack Unit

This block sits in the memory stage of a 32-bit pipeline whose data memory is separate from its instruction memory. For every memory operation that reaches the stage, it drives the address, the read and write strobes and the write data for the data memory. It also holds the stack pointer. The stack pointer is its own register and is not one of the eight general-purpose registers.

Four operations are supported. A load or store addresses memory at a base register value plus a sign-extended 16-bit offset. A push stores the operand at the current stack pointer and then lowers the pointer by two. A pop raises the pointer by two first and reads from the raised value. The stage presents the operation with a valid flag and a stall flag. Only a valid, unstalled operation reaches memory, and only such an operation moves the stack pointer.

Top module: `mstk_unit`

## Requirements
- R1: A load (op_code 2'b00) drives mem_addr = base_val + sign-extended offset, with mem_re=1 and mem_we=0, in the same cycle it is presented.
- R2: A store (op_code 2'b01) drives mem_addr = base_val + sign-extended offset, mem_we=1, mem_re=0 and mem_wdata = store_data.
- R3: The 16-bit offset is sign-extended, so an offset with bit 15 set subtracts (0xFFFF is -1, 0x8000 is -32768).
- R4: A push (op_code 2'b10) drives mem_addr equal to the current sp_out, mem_we=1 and mem_wdata = store_data. After the clock edge, sp_out is two lower.
- R5: A pop (op_code 2'b11) drives mem_re=1 with mem_addr = sp_out + 2. After the clock edge, sp_out equals that address. Popping returns the most recently pushed value.
- R6: Reset (rst_n low) sets sp_out to the parameter SP_TOP.
- R7: sp_out keeps its value across a load, a store, a stalled operation or an operation with op_valid low.
- R8: When op_valid is low or stall is high, mem_we and mem_re are both 0. At most one of the two is ever high.
- R9: Address arithmetic wraps modulo 2^32 (base 0xFFFFFFFF plus offset 1 gives address 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A memory operation is present in the stage |
| stall | input | 1 | The stage is held this cycle |
| op_code | input | 2 | 00 load, 01 store, 10 push, 11 pop |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Offset field, signed |
| store_data | input | 32 | Value written by store or push |
| mem_addr | output | 32 | Data memory address |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| mem_wdata | output | 32 | Data memory write data |
| sp_out | output | 32 | Current stack pointer |

## Verification
Loads and stores are tried with positive, zero and negative offsets and with a base at the top of the address range. These cases separate correct sign extension from zero extension, and correct wraparound from saturation.

A run of pushes followed by pops, checked against a memory model, shows whether the push writes before it decrements and the pop increments before it reads. Off-by-two slips and a reversed order both show up as wrong data or a wrong address.

Stalled and invalid operations are placed between the stack operations to show that the pointer and the strobes stay quiet. Random mixed traffic then exercises every operation after every other operation.

// File: rtl/mstk_pkg.sv
package mstk_pkg;
  typedef enum logic [1:0] {
    MOP_LOAD  = 2'b00,
    MOP_STORE = 2'b01,
    MOP_PUSH  = 2'b10,
    MOP_POP   = 2'b11
  } mem_op_e;
endpackage

// File: rtl/mstk_sp_reg.sv
module mstk_sp_reg #(
  parameter int          AW     = 32,
  parameter logic [31:0] SP_TOP = 32'h0000_1000,
  parameter int          STEP   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_fire,
  input  logic          pop_fire,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_up
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] TOP_V  = AW'(SP_TOP);

  function automatic logic [AW-1:0] sp_adjust(input logic [AW-1:0] sp, input logic up);
    return up ? sp + STEP_V : sp - STEP_V;
  endfunction

  logic [AW-1:0] sp_down;
  assign sp_up   = sp_adjust(sp_q, 1'b1);
  assign sp_down = sp_adjust(sp_q, 1'b0);

  always_ff @(posedge clk) begin
    if (!rst_n)         sp_q <= TOP_V;
    else if (push_fire) sp_q <= sp_down;
    else if (pop_fire)  sp_q <= sp_up;
  end

  AST_PUSH_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_q == $past(sp_q) - STEP_V); // R4
  AST_POP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> sp_q == $past(sp_q) + STEP_V); // R5
  AST_SP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_fire || pop_fire) |=> $stable(sp_q)); // R7
  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_fire && pop_fire)); // R5
endmodule

// File: rtl/mstk_addr_gen.sv
module mstk_addr_gen
  import mstk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  mem_op_e       op,
  input  logic [AW-1:0] base_val,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] store_data,
  input  logic [AW-1:0] sp_q,
  input  logic [AW-1:0] sp_up,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata
);
  localparam int EXT_W = AW - OW;

  function automatic logic [AW-1:0] ea_calc(input logic [AW-1:0] b, input logic [OW-1:0] o);
    return b + {{EXT_W{o[OW-1]}}, o};
  endfunction

  logic [AW-1:0] eff_addr;
  logic          is_write;
  logic          is_read;

  assign eff_addr = ea_calc(base_val, offset);
  assign is_write = (op == MOP_STORE) || (op == MOP_PUSH);
  assign is_read  = (op == MOP_LOAD)  || (op == MOP_POP);

  always_comb begin
    unique case (op)
      MOP_PUSH: mem_addr = sp_q;
      MOP_POP:  mem_addr = sp_up;
      default:  mem_addr = eff_addr;
    endcase
  end

  assign mem_we    = fire && is_write;
  assign mem_re    = fire && is_read;
  assign mem_wdata = mem_we ? store_data : '0;

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> !mem_we && !mem_re); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re})); // R8
  AST_PUSH_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == MOP_PUSH) |-> mem_we && mem_addr == sp_q); // R4
  AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == MOP_STORE) |-> mem_we && mem_wdata == store_data); // R2
endmodule

// File: rtl/mstk_unit.sv
module mstk_unit
  import mstk_pkg::*;
#(
  parameter int          AW     = 32,
  parameter int          DW     = 32,
  parameter int          OW     = 16,
  parameter logic [31:0] SP_TOP = 32'h0000_1000,
  parameter int          STEP   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          stall,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] base_val,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] store_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] sp_out
);
  mem_op_e       op;
  logic          fire;
  logic          push_fire;
  logic          pop_fire;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_up;

  assign op        = mem_op_e'(op_code);
  assign fire      = op_valid && !stall;
  assign push_fire = fire && (op == MOP_PUSH);
  assign pop_fire  = fire && (op == MOP_POP);
  assign sp_out    = sp_q;

  mstk_sp_reg #(.AW(AW), .SP_TOP(SP_TOP), .STEP(STEP)) u_sp (
    .clk(clk), .rst_n(rst_n), .push_fire(push_fire), .pop_fire(pop_fire),
    .sp_q(sp_q), .sp_up(sp_up)
  );

  mstk_addr_gen #(.AW(AW), .DW(DW), .OW(OW)) u_ag (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .base_val(base_val),
    .offset(offset), .store_data(store_data), .sp_q(sp_q), .sp_up(sp_up),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata)
  );

  AST_POP_LANDS_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> sp_out == $past(mem_addr)); // R5
  AST_RESET_TOP: assert property (@(posedge clk)
    !rst_n |=> sp_out == AW'(SP_TOP)); // R6
endmodule

// File: tb/test_mstk_unit.sv
module test_mstk_unit;
  localparam logic [31:0] TOP = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        stall = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [31:0] base_val = '0;
  logic [15:0] offset = '0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_addr, mem_wdata, sp_out;
  logic        mem_we, mem_re;

  int errors = 0;
  int checks = 0;
  logic [31:0] sp_m;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] lifo [$];

  always #5 clk = ~clk;

  mstk_unit #(.SP_TOP(TOP)) i_mstk_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .stall(stall), .op_code(op_code),
    .base_val(base_val), .offset(offset), .store_data(store_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .sp_out(sp_out)
  );

  function automatic logic [31:0] exp_ea(input logic [31:0] b, input logic [15:0] o);
    int signed so;
    so = int'($signed(o));
    return b + 32'(so);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at negedge, check before posedge, update model after it
  task automatic do_op(input logic [1:0] k, input logic v, input logic s,
                       input logic [31:0] b, input logic [15:0] o, input logic [31:0] d,
                       input bit lifo_chk);
    logic go;
    @(negedge clk);
    op_valid = v; stall = s; op_code = k; base_val = b; offset = o; store_data = d;
    #2;
    go = v && !s;
    check("R7 sp before op", sp_out, sp_m);
    if (!go) begin
      check("R8 we idle", {31'd0, mem_we}, 32'd0);
      check("R8 re idle", {31'd0, mem_re}, 32'd0);
    end else begin
      case (k)
        2'b00: begin
          check("R1 load addr", mem_addr, exp_ea(b, o));
          check("R1 load re/we", {30'd0, mem_re, mem_we}, 32'd2);
        end
        2'b01: begin
          check("R2 store addr", mem_addr, exp_ea(b, o));
          check("R2 store re/we", {30'd0, mem_re, mem_we}, 32'd1);
          check("R2 store data", mem_wdata, d);
        end
        2'b10: begin
          check("R4 push addr", mem_addr, sp_m);
          check("R4 push re/we", {30'd0, mem_re, mem_we}, 32'd1);
          check("R4 push data", mem_wdata, d);
        end
        default: begin
          check("R5 pop addr", mem_addr, sp_m + 32'd2);
          check("R5 pop re/we", {30'd0, mem_re, mem_we}, 32'd2);
          if (lifo_chk && lifo.size() > 0)
            check("R5 pop data", mem.exists(mem_addr) ? mem[mem_addr] : 32'hDEAD_BEEF, lifo.pop_back());
        end
      endcase
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
    @(posedge clk);
    #1;
    if (go && k == 2'b10) begin sp_m = sp_m - 32'd2; if (lifo_chk) lifo.push_back(d); end
    if (go && k == 2'b11) sp_m = sp_m + 32'd2;
    check(go && k[1] ? "R4/R5 sp after stack op" : "R7 sp held", sp_out, sp_m);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    sp_m = TOP;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check("R6 reset sp", sp_out, TOP);
    // R1/R3 offsets
    do_op(2'b00, 1, 0, 32'h0000_2000, 16'h7FFF, 0, 0);
    do_op(2'b00, 1, 0, 32'h0000_2000, 16'h8000, 0, 0);
    do_op(2'b00, 1, 0, 32'h0000_2000, 16'hFFFF, 0, 0);
    do_op(2'b00, 1, 0, 32'h0000_2000, 16'h0000, 0, 0);
    // R2 store, R9 wrap
    do_op(2'b01, 1, 0, 32'h0000_0100, 16'hFFF0, 32'hCAFE_0001, 0);
    do_op(2'b00, 1, 0, 32'hFFFF_FFFF, 16'h0001, 0, 0);
    check("R9 wrap addr", mem_addr, 32'h0);
    do_op(2'b01, 1, 0, 32'h0000_0004, 16'h8000, 32'h1234_5678, 0);
    // R4/R5 LIFO with stalls and invalids in between (R7, R8)
    do_op(2'b10, 1, 0, 0, 0, 32'hAAAA_0001, 1);
    do_op(2'b10, 1, 1, 0, 0, 32'hBAD0_0000, 1);
    do_op(2'b10, 1, 0, 0, 0, 32'hAAAA_0002, 1);
    do_op(2'b11, 0, 0, 0, 0, 0, 1);
    do_op(2'b10, 1, 0, 0, 0, 32'hAAAA_0003, 1);
    do_op(2'b11, 1, 0, 0, 0, 0, 1);
    do_op(2'b11, 1, 1, 0, 0, 0, 1);
    do_op(2'b11, 1, 0, 0, 0, 0, 1);
    do_op(2'b11, 1, 0, 0, 0, 0, 1);
    check("R5 sp back at top", sp_out, TOP);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  rk;
      logic        rv, rs;
      rk = 2'($urandom_range(0, 3));
      rv = ($urandom_range(0, 9) != 0);
      rs = ($urandom_range(0, 7) == 0);
      do_op(rk, rv, rs, $urandom, 16'($urandom), $urandom, 0);
    end
    // reset mid-run (R6)
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R6 reset again", sp_out, TOP);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule